// File: doc/BRIEF.md
# GPIO Bank Pin-Event Interrupt Unit

This block watches the GPIO input pins of one bank, made of several ports of several pins each, and turns pin activity into a single interrupt line. Each pin has a three-bit trigger setting that selects one of five conditions: low level, high level, rising edge, falling edge or either edge. The pins arrive already synchronized to the block clock. A pin whose condition is met sets its status bit, and that bit stays set until software writes a one to the matching position of the clear register.

Each pin also has an enable bit. The bank interrupt output is high whenever any pin in any port has both its status bit and its enable bit set. Software reaches each port through a small register window. In that window, plain writes replace a whole register. Masked aliases change the enable or trigger setting of only the selected pins, so no read-modify-write sequence is needed.

Top module: `gpio_bank_irq`

## Requirements
- R1: While reset is held, and at its release, every status, enable and trigger bit is zero and `irq` is low.
- R2: The trigger word of a port carries the high/polarity bit of pin n at bit n, its edge-select bit at bit n+NPIN and its both-edges bit at bit n+2*NPIN. With edge-select at 0 the pin is level sensitive: it is active on a low input when the high bit is 0 and on a high input when the high bit is 1. The both-edges bit is ignored in this case.
- R3: With edge-select at 1, the input sampled at a clock edge is compared with the input sampled one cycle earlier. Both-edges set selects any change. Otherwise the high bit at 1 selects a 0-to-1 change (rising) and at 0 selects a 1-to-0 change (falling).
- R4: A detected event sets the pin's status bit at the clock edge where the input is sampled, whether or not the pin is enabled. The status bit then stays set without further events.
- R5: A write to register code 3 clears the status bits at the positions where the data word has ones; zero bits have no effect. If an event for the same pin is detected in the same cycle, the event wins. A level that is still active therefore keeps the bit set.
- R6: `irq` is the OR, over all ports and pins, of status AND enable. It follows the registers with no extra cycle.
- R7: Register code 1 is the enable register. A write to code 4 updates only the enable bits selected by wdata[2*NPIN-1:NPIN], loading them from wdata[NPIN-1:0].
- R8: Register code 2 is the trigger word. A write to code 5 loads the mode in wdata[NPIN+2:NPIN] (bit NPIN high, NPIN+1 edge, NPIN+2 both) into every pin selected in wdata[NPIN-1:0], and leaves the other pins unchanged.
- R9: addr[2:0] selects the register code and the upper address bits select the port. Code 0 reads status and ignores writes. Code 6 reads the port's input pins. Codes 3 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPORT*NPIN | Synchronized pin levels, port p pin n at bit p*NPIN+n |
| wr_en | input | 1 | Register write strobe |
| addr | input | PW+3 | Port number above a three-bit register code |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Bank interrupt line |

## Verification
The bench uses the default build of four ports with eight pins each. With these values, bit positions n+8 and n+16 of the trigger word are real lanes. Port addressing reaches a port other than zero, and a pin on the last port can raise the shared line. A table covers every trigger code, including the case where the both-edges bit is set while the pin is level sensitive. Each table entry pairs an input transition with a clear in the same cycle, which shows that the event wins. Directed cases then cover enable gating, re-assertion of an active level, the masked aliases and the read-only and zero-reading codes.

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPORT = 4,
  parameter int NPIN  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT*NPIN-1:0]  pin_in,
  input  logic                   wr_en,
  input  logic [((NPORT > 1) ? $clog2(NPORT) : 1)+2:0] addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   irq
);
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int NB = NPORT * NPIN;
  localparam logic [2:0] C_STAT = 3'd0, C_EN = 3'd1, C_TRIG = 3'd2, C_CLR = 3'd3,
                         C_ENM = 3'd4, C_TRM = 3'd5, C_PIN = 3'd6;

  logic [NB-1:0] stat_q, en_q, hi_q, edg_q, both_q, prev_q;
  logic [NB-1:0] en_d, hi_d, edg_d, both_d;
  logic [NB-1:0] clr_vec, emask_vec, tsel_vec;
  logic [NB-1:0] lvl_ev, edg_ev, ev;
  logic [2:0]    code;
  logic [PW-1:0] port;
  logic          port_ok;
  int            base;

  assign code    = addr[2:0];
  assign port    = addr[3 +: PW];
  assign port_ok = 32'(port) < NPORT;
  assign base    = int'(port) * NPIN;

  always_comb begin
    en_d = en_q; hi_d = hi_q; edg_d = edg_q; both_d = both_q;
    clr_vec = '0; emask_vec = '0; tsel_vec = '0;
    if (wr_en && port_ok) begin
      case (code)
        C_EN:   en_d[base +: NPIN] = wdata[NPIN-1:0];
        C_TRIG: begin
          hi_d[base +: NPIN]   = wdata[NPIN-1:0];
          edg_d[base +: NPIN]  = wdata[NPIN +: NPIN];
          both_d[base +: NPIN] = wdata[2*NPIN +: NPIN];
        end
        C_CLR:  clr_vec[base +: NPIN] = wdata[NPIN-1:0];
        C_ENM: begin
          emask_vec[base +: NPIN] = wdata[NPIN +: NPIN];
          en_d[base +: NPIN] = (en_q[base +: NPIN] & ~wdata[NPIN +: NPIN]) |
                               (wdata[NPIN-1:0] & wdata[NPIN +: NPIN]);
        end
        C_TRM: begin
          tsel_vec[base +: NPIN] = wdata[NPIN-1:0];
          for (int i = 0; i < NPIN; i++) begin
            if (wdata[i]) begin
              hi_d[base+i]   = wdata[NPIN];
              edg_d[base+i]  = wdata[NPIN+1];
              both_d[base+i] = wdata[NPIN+2];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign lvl_ev = ~edg_q & ~(pin_in ^ hi_q);
  assign edg_ev = edg_q & ((both_q & (pin_in ^ prev_q)) |
                           (~both_q & hi_q & pin_in & ~prev_q) |
                           (~both_q & ~hi_q & ~pin_in & prev_q));
  assign ev = lvl_ev | edg_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0; en_q <= '0; hi_q <= '0; edg_q <= '0; both_q <= '0; prev_q <= '0;
    end else begin
      stat_q <= ev | (stat_q & ~clr_vec);
      en_q   <= en_d;
      hi_q   <= hi_d;
      edg_q  <= edg_d;
      both_q <= both_d;
      prev_q <= pin_in;
    end
  end

  assign irq = |(stat_q & en_q);

  always_comb begin
    rdata = '0;
    if (port_ok) begin
      case (code)
        C_STAT: rdata[NPIN-1:0] = stat_q[base +: NPIN];
        C_EN:   rdata[NPIN-1:0] = en_q[base +: NPIN];
        C_TRIG: begin
          rdata[NPIN-1:0]      = hi_q[base +: NPIN];
          rdata[NPIN +: NPIN]  = edg_q[base +: NPIN];
          rdata[2*NPIN +: NPIN] = both_q[base +: NPIN];
        end
        C_PIN:  rdata[NPIN-1:0] = pin_in[base +: NPIN];
        default: ;
      endcase
    end
  end

  // R4: a status bit only falls when a clear selected it
  assert_sticky_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat_q & $past(stat_q) & ~$past(clr_vec)) == '0));

  // R2: an active high level under level-high mode is latched at the next edge
  assert_level_high_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pin_in & hi_q & ~edg_q) & ~stat_q) == '0));

  // R6: with no pin enabled the line stays low
  assert_no_irq_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  // R7: masked enable write leaves unselected pins alone
  assert_masked_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && code == C_ENM) |=> (((en_q ^ $past(en_q)) & ~$past(emask_vec)) == '0));

  // R8: masked trigger write leaves unselected pins alone
  assert_masked_trigger_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && code == C_TRM) |=>
      ((((hi_q ^ $past(hi_q)) | (edg_q ^ $past(edg_q)) | (both_q ^ $past(both_q)))
        & ~$past(tsel_vec)) == '0));
endmodule

// File: tb/test_gpio_bank_irq.sv
`timescale 1ns/1ps
module test_gpio_bank_irq;
  localparam int NPORT = 4, NPIN = 8;
  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [NPORT*NPIN-1:0] pins = '1;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  int checks = 0, failures = 0;
  bit done = 0;

  gpio_bank_irq #(.NPORT(NPORT), .NPIN(NPIN)) i_gpio_bank_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  // {trig[2:0] = {both,edge,high}, previous input, new input, expected status}
  localparam logic [5:0] VEC [17] = '{
    {3'b000,1'b1,1'b0,1'b1}, {3'b000,1'b1,1'b1,1'b0}, {3'b000,1'b0,1'b0,1'b1},
    {3'b001,1'b0,1'b1,1'b1}, {3'b001,1'b1,1'b0,1'b0}, {3'b001,1'b1,1'b1,1'b1},
    {3'b011,1'b0,1'b1,1'b1}, {3'b011,1'b1,1'b1,1'b0}, {3'b011,1'b1,1'b0,1'b0},
    {3'b010,1'b1,1'b0,1'b1}, {3'b010,1'b0,1'b1,1'b0}, {3'b010,1'b0,1'b0,1'b0},
    {3'b110,1'b0,1'b1,1'b1}, {3'b110,1'b1,1'b0,1'b1}, {3'b110,1'b1,1'b1,1'b0},
    {3'b111,1'b1,1'b0,1'b1}, {3'b100,1'b0,1'b0,1'b1}};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(int port, int code, logic [31:0] d);
    addr = 5'((port << 3) | code); wdata = d; wr_en = 1;
    step();
    wr_en = 0;
  endtask

  task automatic rd(int port, int code, output logic [31:0] d);
    addr = 5'((port << 3) | code); #1; d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    rd(0, 0, v); chk("R1 status", v, 0);
    rd(0, 1, v); chk("R1 enable", v, 0);
    rd(3, 2, v); chk("R1 trigger", v, 0);
    chk("R1 irq", irq, 0);

    for (int k = 0; k < 17; k++) begin
      logic [2:0] t;
      t = VEC[k][5:3];
      pins[0] = VEC[k][2];
      wr(0, 2, (32'(t[2]) << 16) | (32'(t[1]) << 8) | 32'(t[0]));
      step();
      pins[0] = VEC[k][1];
      wr(0, 3, 32'h1);
      rd(0, 0, v);
      if (t[1]) chk($sformatf("R3 R5 edge row %0d", k), v, 32'(VEC[k][0]));
      else      chk($sformatf("R2 R5 level row %0d", k), v, 32'(VEC[k][0]));
      chk($sformatf("R4 disabled irq row %0d", k), irq, 0);
    end
    pins[0] = 1; wr(0, 2, 0); wr(0, 3, 32'hFF);

    wr(2, 2, 32'h10); step();
    rd(2, 0, v); chk("R4 latched while disabled", v, 32'h10);
    chk("R6 irq gated", irq, 0);
    wr(2, 1, 32'h10); chk("R6 irq asserted", irq, 1);
    pins[20] = 0; wr(2, 3, 32'h10);
    rd(2, 0, v); chk("R5 clear", v, 0);
    chk("R6 irq after clear", irq, 0);

    pins[20] = 1; step();
    wr(2, 3, 32'h10);
    rd(2, 0, v); chk("R5 active level re-sets", v, 32'h10);
    wr(2, 3, 32'h0);
    rd(2, 0, v); chk("R5 zero clear no effect", v, 32'h10);
    wr(2, 4, 32'h1000);
    rd(2, 1, v); chk("R7 masked disable", v, 0);
    chk("R7 irq after masked disable", irq, 0);
    pins[20] = 0; wr(2, 3, 32'h10);
    wr(2, 0, 32'hFF);
    rd(2, 0, v); chk("R9 status write ignored", v, 0);

    wr(1, 1, 32'hA5); wr(1, 4, 32'h0F03);
    rd(1, 1, v); chk("R7 masked enable", v, 32'hA3);
    wr(1, 2, 32'h0000FFFF); wr(1, 5, 32'h0420);
    rd(1, 2, v); chk("R8 masked trigger", v, 32'h0020DFDF);

    wr(3, 2, 32'h8000); wr(3, 1, 32'h80);
    chk("R6 idle irq", irq, 0);
    pins[31] = 0; step();
    rd(3, 0, v); chk("R3 falling on port 3", v, 32'h80);
    chk("R6 bank irq from port 3", irq, 1);
    step();
    rd(3, 0, v); chk("R4 sticky", v, 32'h80);
    rd(3, 6, v); chk("R9 input read", v, 32'h7F);
    rd(3, 3, v); chk("R9 clear reads zero", v, 0);
    rd(3, 7, v); chk("R9 code 7 reads zero", v, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule